// File: doc/BRIEF.md
# Register-Pointer I2C Sensor Target

This block is the register layer of an I2C target that publishes six 16-bit measurement results: four distance channels, a supply voltage and a second forward distance. A separate bit engine handles SCL/SDA and hands the block one-cycle byte events. Those events are: an address byte arrived, a write data byte arrived, the controller wants the next read byte, and the transfer ended through a stop or a bus error. For each byte event the block answers one cycle later with an ACK/NAK decision and, for reads, the byte to shift out.

An 8-bit register pointer selects what is read. The first data byte of a write transfer loads the pointer. Every 16-bit result is read as a pair, high byte first. Reading the high byte captures the whole word, so the low byte that follows always belongs to the same sample. When the pointer is loaded with the address of one of three range channels, that channel gets a one-cycle start pulse, so selecting a distance register also launches its measurement. A key byte written to the top register raises a level request for a firmware-update jump.

Top module: `i2c_regmap_target`

## Requirements
- R1: An address event with byte 0x52 (7-bit address 0x29, bit 0 = 0) or 0x53 (bit 0 = 1) is ACKed. Any other address byte is NAKed with `resp_byte` 0x00 and leaves the block idle.
- R2: A matched write address (0x52) sets the pointer to 0x00 and is ACKed with `resp_byte` 0x00.
- R3: A write data byte received while the pointer is 0x00 becomes the new pointer and is ACKed, with no increment afterwards. Writing 0x00 therefore leaves the next byte as another pointer load.
- R4: Loading the pointer with 0x05, 0x07 or 0x0B raises `range_start` bit 0, 1 or 2 respectively for exactly one cycle, in the same cycle as the response. No other written byte raises any bit.
- R5: A write data byte at pointer 0xFF is NAKed. It sets `boot_req` to 1 if the byte is 0xA5 and to 0 otherwise, and the pointer wraps to 0x00.
- R6: A write data byte at any pointer other than 0x00 and 0xFF is NAKed and discarded, and the pointer increments.
- R7: A read at the pointer returns and ACKs the following. Pointer 0x01 gives the left high byte, 0x03 right, 0x05 and 0x15 forward-1, 0x07 and 0x17 backward, 0x09 voltage, and 0x0B and 0x19 forward-2. The next address up returns the low byte. The pointer increments after every read byte, including the byte sent in reply to a read address.
- R8: A high-byte read (odd mapped pointer) captures the full 16-bit source into a holding register. A low-byte read (even mapped pointer) returns the holding register's low byte, whatever the source holds at that moment.
- R9: A read at an unmapped pointer returns 0x00 with NAK and still increments the pointer. The pointer wraps from 0xFF to 0x00.
- R10: A stop/error event returns the block to idle with no response. While idle, data and read-request events are ignored: `resp_valid` stays 0 and the pointer is unchanged.
- R11: Responses are registered. `resp_valid` pulses one cycle after each accepted byte event. After reset all outputs are 0 and the pointer is 0x00.
- R12: `boot_req` is a level that changes only on a data write at pointer 0xFF and is cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_addr | input | 1 | Address byte received (byte on `in_byte`) |
| ev_data | input | 1 | Write data byte received (byte on `in_byte`) |
| ev_req | input | 1 | Controller requests the next read byte |
| ev_idle | input | 1 | Stop or bus error seen |
| in_byte | input | 8 | Byte delivered with `ev_addr` / `ev_data` |
| sens_left | input | 16 | Left distance result |
| sens_right | input | 16 | Right distance result |
| sens_fwd1 | input | 16 | Forward-1 distance result |
| sens_bwd | input | 16 | Backward distance result |
| sens_volt | input | 16 | Supply voltage result |
| sens_fwd2 | input | 16 | Forward-2 distance result |
| resp_valid | output | 1 | One-cycle strobe: response fields valid |
| resp_ack | output | 1 | 1 = ACK, 0 = NAK |
| resp_byte | output | 8 | Byte to transmit (0x00 for non-read responses) |
| range_start | output | 3 | One-cycle start pulses: bit0 forward-1, bit1 backward, bit2 forward-2 |
| boot_req | output | 1 | Firmware-update request level |

## Verification
The bench changes a source between the high-byte and low-byte reads. A design that reads the low byte live instead of from the capture would return the new value. It also reads a low byte straight after a re-addressing, which must come from the last capture and not from the source. Pointer-load corners are covered as well: a write of 0x00 as the pointer must leave the next byte as a load, a register written at 0xFF must wrap the pointer, and a mirror address must not fire a range pulse. A design that incremented after a load, or that decoded pulses on data writes rather than on pointer loads, would show a wrong read or a stray pulse. Unmapped reads at 0x0D, 0x1B and 0xFF check that the pointer still advances and that NAK comes with 0x00.

// File: rtl/i2c_rm_pkg.sv
package i2c_rm_pkg;
  localparam int BYTE_W  = 8;
  localparam int SENS_W  = 16;
  localparam int N_SRC   = 6;
  localparam int N_RANGE = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ} bus_state_t;

  typedef enum logic [2:0] {
    SRC_LEFT  = 3'd0,
    SRC_RIGHT = 3'd1,
    SRC_FWD1  = 3'd2,
    SRC_BWD   = 3'd3,
    SRC_VOLT  = 3'd4,
    SRC_FWD2  = 3'd5,
    SRC_NONE  = 3'd7
  } src_t;

  // pointer values that launch a range channel, index = range_start bit
  localparam logic [BYTE_W-1:0] RANGE_LOAD [N_RANGE] = '{8'h05, 8'h07, 8'h0B};

  function automatic src_t map_src(input logic [BYTE_W-1:0] p);
    case (p)
      8'h01, 8'h02:               map_src = SRC_LEFT;
      8'h03, 8'h04:               map_src = SRC_RIGHT;
      8'h05, 8'h06, 8'h15, 8'h16: map_src = SRC_FWD1;
      8'h07, 8'h08, 8'h17, 8'h18: map_src = SRC_BWD;
      8'h09, 8'h0A:               map_src = SRC_VOLT;
      8'h0B, 8'h0C, 8'h19, 8'h1A: map_src = SRC_FWD2;
      default:                    map_src = SRC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/rm_read_path.sv
module rm_read_path
  import i2c_rm_pkg::*;
#(
  parameter int W  = SENS_W,
  parameter int NS = N_SRC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [BYTE_W-1:0] ptr,
  input  logic [NS*W-1:0]   sens_flat,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              rd_hit
);
  src_t         sel;
  logic         is_hi;
  logic [W-1:0] src_word;
  logic [W-1:0] hold;
  int           idx;

  always_comb begin
    sel      = map_src(ptr);
    rd_hit   = (sel != SRC_NONE);
    is_hi    = ptr[0];
    idx      = rd_hit ? int'(sel) : 0;
    src_word = sens_flat[idx*W +: W];
    if (!rd_hit)    rd_byte = '0;
    else if (is_hi) rd_byte = src_word[W-1 -: BYTE_W];
    else            rd_byte = hold[BYTE_W-1:0];
  end

  // R8: coherent pair read through the holding register
  always_ff @(posedge clk) begin
    if (rst)                         hold <= '0;
    else if (fire && rd_hit && is_hi) hold <= src_word;
  end
endmodule

// File: rtl/rm_write_path.sv
module rm_write_path
  import i2c_rm_pkg::*;
#(
  parameter logic [BYTE_W-1:0] BOOT_REG = 8'hFF,
  parameter logic [BYTE_W-1:0] BOOT_KEY = 8'hA5,
  parameter int                NR       = N_RANGE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [BYTE_W-1:0] ptr,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] ptr_next,
  output logic              wr_ack,
  output logic [NR-1:0]     range_start,
  output logic              boot_req
);
  logic is_load;

  always_comb begin
    is_load  = (ptr == '0);
    wr_ack   = is_load;                              // R3, R5, R6
    ptr_next = is_load ? wbyte : ptr + 8'd1;         // wraps at 0xFF
  end

  // R4: one start pulse per range channel
  for (genvar g = 0; g < NR; g++) begin : g_range
    always_ff @(posedge clk) begin
      if (rst) range_start[g] <= 1'b0;
      else     range_start[g] <= fire && is_load && (wbyte == RANGE_LOAD[g]);
    end
  end

  // R5, R12
  always_ff @(posedge clk) begin
    if (rst)                          boot_req <= 1'b0;
    else if (fire && ptr == BOOT_REG) boot_req <= (wbyte == BOOT_KEY);
  end
endmodule

// File: rtl/i2c_regmap_target.sv
module i2c_regmap_target
  import i2c_rm_pkg::*;
#(
  parameter logic [6:0]        TARGET_ADDR = 7'h29,
  parameter logic [BYTE_W-1:0] BOOT_REG    = 8'hFF,
  parameter logic [BYTE_W-1:0] BOOT_KEY    = 8'hA5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_addr,
  input  logic              ev_data,
  input  logic              ev_req,
  input  logic              ev_idle,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic [SENS_W-1:0] sens_left,
  input  logic [SENS_W-1:0] sens_right,
  input  logic [SENS_W-1:0] sens_fwd1,
  input  logic [SENS_W-1:0] sens_bwd,
  input  logic [SENS_W-1:0] sens_volt,
  input  logic [SENS_W-1:0] sens_fwd2,
  output logic              resp_valid,
  output logic              resp_ack,
  output logic [BYTE_W-1:0] resp_byte,
  output logic [N_RANGE-1:0] range_start,
  output logic              boot_req
);
  bus_state_t        state;
  logic [BYTE_W-1:0] ptr;
  logic              addr_match, wr_fire, rd_fire;
  logic [BYTE_W-1:0] rd_byte, ptr_next;
  logic              rd_hit, wr_ack;
  logic [N_SRC*SENS_W-1:0] sens_flat;

  // source order follows the src_t encoding
  assign sens_flat = {sens_fwd2, sens_volt, sens_bwd, sens_fwd1, sens_right, sens_left};

  always_comb begin
    addr_match = (in_byte[BYTE_W-1:1] == TARGET_ADDR);
    wr_fire    = !ev_idle && !ev_addr && ev_data && (state == ST_WRITE);
    rd_fire    = !ev_idle && ((ev_addr && addr_match && in_byte[0]) ||
                              (!ev_addr && ev_req && state == ST_READ));
  end

  rm_read_path #(.W(SENS_W), .NS(N_SRC)) u_rd (
    .clk(clk), .rst(rst), .fire(rd_fire), .ptr(ptr),
    .sens_flat(sens_flat), .rd_byte(rd_byte), .rd_hit(rd_hit)
  );

  rm_write_path #(.BOOT_REG(BOOT_REG), .BOOT_KEY(BOOT_KEY), .NR(N_RANGE)) u_wr (
    .clk(clk), .rst(rst), .fire(wr_fire), .ptr(ptr), .wbyte(in_byte),
    .ptr_next(ptr_next), .wr_ack(wr_ack), .range_start(range_start),
    .boot_req(boot_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ptr        <= '0;
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      resp_byte  <= '0;
    end else begin
      resp_valid <= 1'b0;
      resp_ack   <= 1'b0;
      resp_byte  <= '0;
      if (ev_idle) begin
        state <= ST_IDLE;                              // R10
      end else if (ev_addr) begin
        resp_valid <= 1'b1;
        if (!addr_match) begin
          state <= ST_IDLE;                            // R1
        end else if (!in_byte[0]) begin
          state    <= ST_WRITE;                        // R2
          ptr      <= '0;
          resp_ack <= 1'b1;
        end else begin
          state     <= ST_READ;                        // R7
          resp_ack  <= rd_hit;
          resp_byte <= rd_byte;
          ptr       <= ptr + 8'd1;
        end
      end else if (wr_fire) begin
        resp_valid <= 1'b1;
        resp_ack   <= wr_ack;
        ptr        <= ptr_next;
      end else if (rd_fire) begin
        resp_valid <= 1'b1;
        resp_ack   <= rd_hit;                          // R9
        resp_byte  <= rd_byte;
        ptr        <= ptr + 8'd1;
      end
    end
  end
endmodule

// File: rtl/i2c_regmap_checker.sv
module i2c_regmap_checker (
  input logic       clk,
  input logic       rst,
  input logic       ev_addr,
  input logic       ev_data,
  input logic       ev_req,
  input logic       resp_valid,
  input logic       resp_ack,
  input logic [7:0] resp_byte,
  input logic [2:0] range_start,
  input logic       boot_req
);
  AST_RANGE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(range_start)); // R4
  AST_RANGE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (|range_start) |=> !(|range_start)); // R4
  AST_RANGE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (|range_start) |-> $past(ev_data)); // R4
  AST_NAK_ZERO_BYTE: assert property (@(posedge clk) disable iff (rst)
    (resp_valid && !resp_ack) |-> (resp_byte == 8'h00)); // R9
  AST_RESP_AFTER_EVENT: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(ev_addr || ev_data || ev_req)); // R11
  AST_BOOT_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$stable(boot_req) |-> $past(ev_data)); // R12
endmodule

bind i2c_regmap_target i2c_regmap_checker u_chk (.*);

// File: tb/i2c_regmap_target_test.sv
module i2c_regmap_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 45;

  logic clk = 0, rst = 1;
  logic ev_addr = 0, ev_data = 0, ev_req = 0, ev_idle = 0;
  logic [7:0] in_byte = 0;
  logic [15:0] sens_left = 16'h1234, sens_right = 16'h5678, sens_fwd1 = 16'h9ABC;
  logic [15:0] sens_bwd = 16'hDEF0, sens_volt = 16'h0A0B, sens_fwd2 = 16'hC0DE;
  logic resp_valid, resp_ack, boot_req;
  logic [7:0] resp_byte;
  logic [2:0] range_start;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_regmap_target uut (.*);

  // {kind, byte, exp_valid, exp_ack, exp_byte, exp_pulse, req}
  // kind: 0 addr, 1 data, 2 read request, 3 stop/error
  localparam logic [26:0] VEC [NV] = '{
    {2'd0,8'h52,1'b1,1'b1,8'h00,3'b000,4'd2},  // R2
    {2'd1,8'h01,1'b1,1'b1,8'h00,3'b000,4'd3},  // R3
    {2'd0,8'h53,1'b1,1'b1,8'h12,3'b000,4'd7},  // R7 left hi
    {2'd2,8'h00,1'b1,1'b1,8'h34,3'b000,4'd8},
    {2'd2,8'h00,1'b1,1'b1,8'h56,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'h78,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'h9A,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'hBC,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'hDE,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'hF0,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'h0A,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'h0B,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'hC0,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'hDE,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b0,8'h00,3'b000,4'd9},  // R9 ptr 0x0D
    {2'd3,8'h00,1'b0,1'b0,8'h00,3'b000,4'd10}, // R10
    {2'd2,8'h00,1'b0,1'b0,8'h00,3'b000,4'd10}, // R10 ignored while idle
    {2'd0,8'h52,1'b1,1'b1,8'h00,3'b000,4'd2},
    {2'd1,8'h07,1'b1,1'b1,8'h00,3'b010,4'd4},  // R4 backward
    {2'd1,8'h55,1'b1,1'b0,8'h00,3'b000,4'd6},  // R6
    {2'd0,8'h53,1'b1,1'b1,8'hDE,3'b000,4'd8},  // R8 low from last capture
    {2'd3,8'h00,1'b0,1'b0,8'h00,3'b000,4'd10},
    {2'd0,8'h52,1'b1,1'b1,8'h00,3'b000,4'd2},
    {2'd1,8'h05,1'b1,1'b1,8'h00,3'b001,4'd4},  // R4 forward-1
    {2'd0,8'h52,1'b1,1'b1,8'h00,3'b000,4'd2},
    {2'd1,8'h0B,1'b1,1'b1,8'h00,3'b100,4'd4},  // R4 forward-2
    {2'd0,8'h53,1'b1,1'b1,8'hC0,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'hDE,3'b000,4'd8},
    {2'd0,8'h52,1'b1,1'b1,8'h00,3'b000,4'd2},
    {2'd1,8'h15,1'b1,1'b1,8'h00,3'b000,4'd4},  // R4 mirror: no pulse
    {2'd0,8'h53,1'b1,1'b1,8'h9A,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'hBC,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'hDE,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'hF0,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'hC0,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'hDE,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b0,8'h00,3'b000,4'd9},  // R9 ptr 0x1B
    {2'd0,8'h50,1'b1,1'b0,8'h00,3'b000,4'd1},  // R1 wrong address
    {2'd1,8'h33,1'b0,1'b0,8'h00,3'b000,4'd10}, // R10 data while idle
    {2'd0,8'h29,1'b1,1'b0,8'h00,3'b000,4'd1},  // R1 unshifted address
    {2'd0,8'h52,1'b1,1'b1,8'h00,3'b000,4'd1},
    {2'd1,8'h00,1'b1,1'b1,8'h00,3'b000,4'd3},  // R3 load 0
    {2'd1,8'h09,1'b1,1'b1,8'h00,3'b000,4'd3},  // R3 still a load
    {2'd0,8'h53,1'b1,1'b1,8'h0A,3'b000,4'd7},
    {2'd2,8'h00,1'b1,1'b1,8'h0B,3'b000,4'd7}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // drive one event for one cycle; outputs are checked at the next negedge
  task automatic ev(input logic [1:0] kind, input logic [7:0] b);
    @(negedge clk);
    in_byte = b;
    ev_addr = (kind == 2'd0);
    ev_data = (kind == 2'd1);
    ev_req  = (kind == 2'd2);
    ev_idle = (kind == 2'd3);
    @(negedge clk);
    ev_addr = 0; ev_data = 0; ev_req = 0; ev_idle = 0;
  endtask

  task automatic expect_resp(input string req, input logic v, input logic a, input logic [7:0] b);
    chk(req, "resp_valid", int'(resp_valid), int'(v));
    chk(req, "resp_ack", int'(resp_ack), int'(a));
    chk(req, "resp_byte", int'(resp_byte), int'(b));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset resp_valid", int'(resp_valid), 0);
    chk("R11", "reset range_start", int'(range_start), 0);
    chk("R12", "reset boot_req", int'(boot_req), 0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d row %0d", VEC[i][3:0], i);
      ev(VEC[i][26:25], VEC[i][24:17]);
      chk(tag, "resp_valid", int'(resp_valid), int'(VEC[i][16]));
      chk(tag, "resp_ack", int'(resp_ack), int'(VEC[i][15]));
      chk(tag, "resp_byte", int'(resp_byte), int'(VEC[i][14:7]));
      chk(tag, "range_start", int'(range_start), int'(VEC[i][6:4]));
    end
    @(negedge clk);
    chk("R4", "pulse gone", int'(range_start), 0);

    // R8 source changes between high and low byte
    ev(2'd3, 8'h00);
    ev(2'd0, 8'h52); ev(2'd1, 8'h01);
    ev(2'd0, 8'h53); expect_resp("R8", 1, 1, 8'h12);
    sens_left = 16'hABCD;
    ev(2'd2, 8'h00); expect_resp("R8", 1, 1, 8'h34);
    ev(2'd3, 8'h00);

    // R5 key write, pointer wrap, then a fresh pointer load
    ev(2'd0, 8'h52); ev(2'd1, 8'hFF);
    ev(2'd1, 8'hA5); expect_resp("R5", 1, 0, 8'h00);
    chk("R5", "boot_req set", int'(boot_req), 1);
    ev(2'd1, 8'h03); expect_resp("R5", 1, 1, 8'h00); // wrapped to 0: load
    ev(2'd0, 8'h53); expect_resp("R7", 1, 1, 8'h56);
    chk("R12", "boot_req held", int'(boot_req), 1);
    ev(2'd3, 8'h00);

    // R5 non-key byte clears the request
    ev(2'd0, 8'h52); ev(2'd1, 8'hFF);
    ev(2'd1, 8'h00); expect_resp("R5", 1, 0, 8'h00);
    chk("R5", "boot_req cleared", int'(boot_req), 0);

    // R9 read pointer wraps at 0xFF
    ev(2'd0, 8'h52); ev(2'd1, 8'hFF);
    ev(2'd0, 8'h53); expect_resp("R9", 1, 0, 8'h00);
    ev(2'd2, 8'h00); expect_resp("R9", 1, 0, 8'h00);
    ev(2'd2, 8'h00); expect_resp("R9", 1, 1, 8'hAB);

    // R12 reset clears the request
    ev(2'd0, 8'h52); ev(2'd1, 8'hFF); ev(2'd1, 8'hA5);
    chk("R12", "boot_req before reset", int'(boot_req), 1);
    rst = 1;
    repeat (3) @(negedge clk);
    chk("R12", "boot_req after reset", int'(boot_req), 0);
    rst = 0;
    ev(2'd0, 8'h53); expect_resp("R11", 1, 0, 8'h00); // pointer back to 0

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule